// File: doc/BRIEF.md
# Condition Register Bit-Logic Unit

This block owns a 32-bit condition register and executes single-bit Boolean instructions against it, one instruction word per cycle. An accepted word is decoded combinationally, two register bits are fetched by absolute 5-bit index, they are combined by one of eight two-input functions, and the result replaces a third indexed bit. A second instruction kind copies one 4-bit field of the register onto another field.

Instruction bits are numbered from the most significant end, so instruction bit 0 is `insn_i[31]`. Register bit indices are numbered the same way: index 0 is the most significant register bit. The register is written on the clock edge that accepts the instruction. A word presented in the next cycle therefore reads the new value, with no stall and no bypass path. A malformed word raises a one-cycle illegal flag and leaves the register alone.

Top module: `cr_bitlogic`

## Requirements
- R1: While `rst_n` is low at a clock edge, the register clears to all zeros and `illegal_o` goes low.
- R2: A word is a logic instruction only if instruction bits 0–5 (`insn_i[31:26]`) equal 19. The other fields are as follows: bits 6–10 (`insn_i[25:21]`) are the destination index, bits 11–15 (`insn_i[20:16]`) are source A, bits 16–20 (`insn_i[15:11]`) are source B, bits 21–30 (`insn_i[10:1]`) are the extended code, and bit 31 (`insn_i[0]`) is the link bit. A word with the link bit set is illegal.
- R3: Extended code 225 is NAND: the destination becomes 0 only when both sources are 1. The word with all operand fields zero is 0x4C0001C2.
- R4: The other extended codes are 257 AND, 129 A AND NOT B, 449 OR, 417 A OR NOT B, 33 NOR, 193 XOR and 289 XNOR.
- R5: Index i addresses register bit 31−i. The three indices are independent and may fall in any fields.
- R6: NAND with both source indices equal writes the complement of that bit, and this includes the case where the destination is the same bit.
- R7: A bit instruction changes no register bit other than its destination.
- R8: Extended code 0 copies a field. Field f is register indices 4f to 4f+3. The destination field is instruction bits 6–8 (`insn_i[25:23]`) and the source field is bits 11–13 (`insn_i[20:18]`). All other fields are unchanged.
- R9: A valid word with a primary opcode other than 19, or with opcode 19 and an unlisted extended code, sets `illegal_o` high in exactly the following cycle and leaves the register unchanged.
- R10: The result is visible on `cr_o` one cycle after acceptance, and an instruction in that very next cycle operates on the updated bits.
- R11: While `insn_valid_i` is low, the register holds and `illegal_o` is low, whatever `insn_i` carries.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_i | input | 32 | Instruction word |
| insn_valid_i | input | 1 | Instruction word is present this cycle |
| illegal_o | output | 1 | Previous cycle's word was malformed |
| cr_o | output | 32 | Current condition register value |

## Verification
The bench builds the block with its default parameters: a 32-bit register and 4-bit fields. With these values every one of the 32 bit indices and all 8 fields can be reached, including the end fields 0 and 7 and the end indices 0 and 31. The random index draws therefore cover sources and destinations that cross field boundaries, as well as all coincidences among the three operands. Back-to-back chains in which each word reads the previous destination check that the same-edge write serves as the forwarding path.

// File: rtl/crlu_pkg.sv
// Shared types for the condition register bit-logic unit.
// Assumes the fixed 32-bit instruction format with MSB-first bit numbering.
package crlu_pkg;

    localparam int INSN_W = 32;
    localparam int XO_W   = 10;

    localparam logic [5:0] PRIM_CRLOGIC = 6'd19;

    localparam logic [XO_W-1:0] XO_FCOPY = 10'd0;
    localparam logic [XO_W-1:0] XO_NOR   = 10'd33;
    localparam logic [XO_W-1:0] XO_ANDC  = 10'd129;
    localparam logic [XO_W-1:0] XO_XOR   = 10'd193;
    localparam logic [XO_W-1:0] XO_NAND  = 10'd225;
    localparam logic [XO_W-1:0] XO_AND   = 10'd257;
    localparam logic [XO_W-1:0] XO_EQV   = 10'd289;
    localparam logic [XO_W-1:0] XO_ORC   = 10'd417;
    localparam logic [XO_W-1:0] XO_OR    = 10'd449;

    typedef enum logic [1:0] {
        K_NOP  = 2'd0,
        K_BIT  = 2'd1,
        K_COPY = 2'd2,
        K_BAD  = 2'd3
    } kind_t;

    typedef enum logic [2:0] {
        F_AND  = 3'd0,
        F_ANDC = 3'd1,
        F_OR   = 3'd2,
        F_ORC  = 3'd3,
        F_NOR  = 3'd4,
        F_XOR  = 3'd5,
        F_EQV  = 3'd6,
        F_NAND = 3'd7
    } func_t;

    typedef struct packed {
        kind_t      kind;
        func_t      func;
        logic [4:0] dst;
        logic [4:0] srca;
        logic [4:0] srcb;
    } op_t;

endpackage

// File: rtl/crlu_decode.sv
// Instruction decoder: splits the word into fields and classifies it.
// Assumes MSB-first numbering: instruction bit 0 is insn_i[31].
// A word with the link bit set, a foreign primary opcode, or an unlisted
// extended code is classed K_BAD; an absent word is K_NOP.
module crlu_decode
    import crlu_pkg::*;
(
    input  logic [INSN_W-1:0] insn_i,
    input  logic              valid_i,
    output op_t               op_o
);

    logic [5:0]      prim;
    logic [XO_W-1:0] xo;
    logic            link;

    assign prim = insn_i[31:26];
    assign xo   = insn_i[10:1];
    assign link = insn_i[0];

    // Classify the word and pick the Boolean function.
    always_comb begin
        op_o.dst  = insn_i[25:21];
        op_o.srca = insn_i[20:16];
        op_o.srcb = insn_i[15:11];
        op_o.func = F_AND;
        op_o.kind = K_BAD;
        if (!valid_i) begin
            op_o.kind = K_NOP;
        end else if (prim == PRIM_CRLOGIC && !link) begin
            op_o.kind = K_BIT;
            case (xo)
                XO_FCOPY: op_o.kind = K_COPY;
                XO_AND:   op_o.func = F_AND;
                XO_ANDC:  op_o.func = F_ANDC;
                XO_OR:    op_o.func = F_OR;
                XO_ORC:   op_o.func = F_ORC;
                XO_NOR:   op_o.func = F_NOR;
                XO_XOR:   op_o.func = F_XOR;
                XO_EQV:   op_o.func = F_EQV;
                XO_NAND:  op_o.func = F_NAND;
                default:  op_o.kind = K_BAD;
            endcase
        end
    end

endmodule

// File: rtl/crlu_bitop.sv
// Two-input Boolean function selected by func_i. Pure combinational.
module crlu_bitop
    import crlu_pkg::*;
(
    input  logic  a_i,
    input  logic  b_i,
    input  func_t func_i,
    output logic  y_o
);

    // Evaluate the selected function.
    always_comb begin
        case (func_i)
            F_AND:   y_o = a_i & b_i;
            F_ANDC:  y_o = a_i & ~b_i;
            F_OR:    y_o = a_i | b_i;
            F_ORC:   y_o = a_i | ~b_i;
            F_NOR:   y_o = ~(a_i | b_i);
            F_XOR:   y_o = a_i ^ b_i;
            F_EQV:   y_o = ~(a_i ^ b_i);
            default: y_o = ~(a_i & b_i);
        endcase
    end

endmodule

// File: rtl/crlu_update.sv
// Next-state logic for the register: reads two bits, combines them, and
// inserts the result, or moves one field onto another.
// Assumes index i maps to physical bit REG_W-1-i, and field f covers
// indices FIELD_W*f .. FIELD_W*f+FIELD_W-1.
module crlu_update
    import crlu_pkg::*;
#(
    parameter int REG_W   = 32,
    parameter int FIELD_W = 4
) (
    input  logic [REG_W-1:0] cr_i,
    input  op_t              op_i,
    output logic [REG_W-1:0] cr_nxt_o
);

    localparam int IDX_W  = $clog2(REG_W);
    localparam int NFIELD = REG_W / FIELD_W;
    localparam int FSEL_W = $clog2(NFIELD);

    logic [IDX_W-1:0]  pa, pb, pd, dbase, sbase;
    logic [FSEL_W-1:0] fdst, fsrc;
    logic              a_bit, b_bit, res;

    // Map MSB-first indices and field numbers to physical positions.
    always_comb begin
        pa    = IDX_W'(REG_W - 1) - op_i.srca[IDX_W-1:0];
        pb    = IDX_W'(REG_W - 1) - op_i.srcb[IDX_W-1:0];
        pd    = IDX_W'(REG_W - 1) - op_i.dst[IDX_W-1:0];
        fdst  = op_i.dst[IDX_W-1 -: FSEL_W];
        fsrc  = op_i.srca[IDX_W-1 -: FSEL_W];
        dbase = IDX_W'(REG_W - 1 - FIELD_W * int'(fdst));
        sbase = IDX_W'(REG_W - 1 - FIELD_W * int'(fsrc));
    end

    assign a_bit = cr_i[pa];
    assign b_bit = cr_i[pb];

    crlu_bitop u_fn (
        .a_i    (a_bit),
        .b_i    (b_bit),
        .func_i (op_i.func),
        .y_o    (res)
    );

    // Build the next register value; untouched bits pass through.
    always_comb begin
        cr_nxt_o = cr_i;
        if (op_i.kind == K_BIT) begin
            cr_nxt_o[pd] = res;
        end else if (op_i.kind == K_COPY) begin
            cr_nxt_o[dbase -: FIELD_W] = cr_i[sbase -: FIELD_W];
        end
    end

endmodule

// File: rtl/cr_bitlogic.sv
// Condition register bit-logic unit top. Holds the register, accepts at
// most one word per cycle and commits it on the same edge, so a word in
// the next cycle reads the committed value without a bypass path.
// Assumes a synchronous active-low reset.
module cr_bitlogic
    import crlu_pkg::*;
#(
    parameter int REG_W   = 32,
    parameter int FIELD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INSN_W-1:0] insn_i,
    input  logic              insn_valid_i,
    output logic              illegal_o,
    output logic [REG_W-1:0]  cr_o
);

    op_t              op;
    logic [REG_W-1:0] cr_q, cr_nxt;
    logic             illegal_q;

    crlu_decode u_dec (
        .insn_i  (insn_i),
        .valid_i (insn_valid_i),
        .op_o    (op)
    );

    crlu_update #(.REG_W(REG_W), .FIELD_W(FIELD_W)) u_upd (
        .cr_i     (cr_q),
        .op_i     (op),
        .cr_nxt_o (cr_nxt)
    );

    // Commit the register and the illegal flag each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cr_q      <= '0;
            illegal_q <= 1'b0;
        end else begin
            cr_q      <= cr_nxt;
            illegal_q <= (op.kind == K_BAD);
        end
    end

    assign cr_o      = cr_q;
    assign illegal_o = illegal_q;

    // R7: a bit instruction flips at most one register bit.
    a_r7_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && op.kind == K_BIT) |=> ($countones(cr_q ^ $past(cr_q)) <= 1));

    // R8: a field copy alters at most one field's worth of bits.
    a_r8_copy_span: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && op.kind == K_COPY) |=> ($countones(cr_q ^ $past(cr_q)) <= FIELD_W));

    // R9: a malformed word raises the flag in the next cycle.
    a_r9_flag_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && op.kind == K_BAD) |=> illegal_o);

    // R9: whenever the flag is up, the register did not move.
    a_r9_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> $stable(cr_q));

    // R11: with no word presented, the register holds and no flag follows.
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !insn_valid_i) |=> ($stable(cr_q) && !illegal_o));

endmodule

// File: tb/cr_bitlogic_test.sv
module cr_bitlogic_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] insn_i = '0;
    logic        insn_valid_i = 1'b0;
    logic        illegal_o;
    logic [31:0] cr_o;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] model = '0;

    always #4 clk = ~clk;

    cr_bitlogic uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .insn_i       (insn_i),
        .insn_valid_i (insn_valid_i),
        .illegal_o    (illegal_o),
        .cr_o         (cr_o)
    );

    localparam int XO_LIST [9] = '{0, 33, 129, 193, 225, 257, 289, 417, 449};

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(int xo, int bt, int ba, int bb, bit lk);
        logic [9:0] x = 10'(xo);
        return {6'd19, 5'(bt), 5'(ba), 5'(bb), x, lk};
    endfunction

    // Reference step: returns the new register, sets bad for malformed words.
    function automatic logic [31:0] ref_step(logic [31:0] cr, logic [31:0] w, output bit bad);
        logic [31:0] r = cr;
        int bt = int'(w[25:21]);
        int ba = int'(w[20:16]);
        int bb = int'(w[15:11]);
        int xo = int'(w[10:1]);
        logic a = cr[31-ba];
        logic b = cr[31-bb];
        bad = 1'b0;
        if (w[31:26] != 6'd19 || w[0]) begin
            bad = 1'b1;
            return cr;
        end
        case (xo)
            0: begin
                for (int k = 0; k < 4; k++)
                    r[31 - (4*(bt/4) + k)] = cr[31 - (4*(ba/4) + k)];
            end
            257: r[31-bt] = a & b;
            129: r[31-bt] = a & !b;
            449: r[31-bt] = a | b;
            417: r[31-bt] = a | !b;
            33:  r[31-bt] = !(a | b);
            193: r[31-bt] = a ^ b;
            289: r[31-bt] = !(a ^ b);
            225: r[31-bt] = !(a & b);
            default: bad = 1'b1;
        endcase
        return r;
    endfunction

    // Present one word for one cycle, then compare against the model.
    task automatic drive(logic [31:0] w, string tag);
        bit bad;
        insn_i = w;
        insn_valid_i = 1'b1;
        @(negedge clk);
        model = ref_step(model, w, bad);
        check({tag, " reg"}, cr_o, model);
        check({tag, " flag"}, {31'd0, illegal_o}, {31'd0, bad});
    endtask

    task automatic idle(int n);
        insn_valid_i = 1'b0;
        for (int i = 0; i < n; i++) begin
            insn_i = $urandom;
            @(negedge clk);
            check("R11 idle reg", cr_o, model);
            check("R11 idle flag", {31'd0, illegal_o}, 32'd0);
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset reg", cr_o, 32'd0);
        check("R1 reset flag", {31'd0, illegal_o}, 32'd0);
    endtask

    task automatic t_nand_basic();
        drive(32'h4C0001C2, "R3 nand word");
        check("R5 index0 is msb", cr_o, 32'h8000_0000);
        drive(mk(225, 31, 0, 0, 0), "R6 nand invert");
        check("R6 bit31 clear", cr_o, 32'h8000_0000);
        drive(mk(225, 5, 0, 31, 0), "R3 nand mixed");
        check("R5 cross field", cr_o, 32'h8400_0000);
        idle(1);
    endtask

    task automatic t_all_funcs();
        for (int i = 0; i < 160; i++)
            drive(mk(XO_LIST[1 + (i % 8)], $urandom_range(31), $urandom_range(31),
                     $urandom_range(31), 0), "R4 R5 R7 func");
        idle(1);
    endtask

    task automatic t_same_source();
        for (int i = 0; i < 40; i++) begin
            int s = $urandom_range(31);
            int d = (i % 2 == 0) ? s : $urandom_range(31);
            drive(mk(225, d, s, s, 0), "R6 same source");
        end
    endtask

    task automatic t_copy();
        for (int i = 0; i < 40; i++)
            drive(mk(0, $urandom_range(31), $urandom_range(31), $urandom_range(31), 0),
                  "R8 field copy");
        drive(mk(0, 28, 0, 0, 0), "R8 copy field0 to 7");
        drive(mk(0, 0, 31, 0, 0), "R8 copy field7 to 0");
    endtask

    task automatic t_illegal();
        drive({6'd31, 5'd1, 5'd2, 5'd3, 10'd225, 1'b0}, "R9 foreign opcode");
        drive(mk(16, 3, 4, 5, 0), "R9 unlisted xo");
        drive(mk(225, 7, 7, 7, 1), "R2 link set");
        idle(1);
        check("R9 flag one cycle", {31'd0, illegal_o}, 32'd0);
    endtask

    task automatic t_back_to_back();
        int d = 9;
        for (int i = 0; i < 30; i++) begin
            int nd = $urandom_range(31);
            drive(mk(XO_LIST[1 + (i % 8)], nd, d, $urandom_range(31), 0), "R10 chain");
            d = nd;
        end
        idle(3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_nand_basic();
        t_all_funcs();
        t_same_source();
        t_copy();
        t_illegal();
        t_back_to_back();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule